// File: doc/BRIEF.md
# Encoder/decoder pin mode multiplexer

This block sits between a network controller core, an on-chip Manchester encoder/decoder and eight shared external pins. A two-bit mode field picks one of four arrangements. In the first two, the controller talks to the internal encoder/decoder:

- **Normal:** the pins stay isolated.
- **Monitor:** every pin carries a copy of the matching internal signal, so the link can be observed from outside.

In the other two, the pins carry the serial link:

- **Bypass:** the internal encoder/decoder is shut off. The controller exchanges its serial link with an external encoder/decoder through the pins.
- **Test:** the controller section is shut off. The internal encoder/decoder is driven and observed from the pins, with every pin turned the other way from bypass.

Each pad is modelled as a data output, an output enable and an input. The pins are numbered by the direction they take in bypass:

- **Pins 0 to 2** are the transmit data, transmit enable and loopback-control lines. The controller sources these three.
- **Pins 3 to 7** are the transmit clock, receive data, receive clock, carrier sense and collision lines. The encoder/decoder sources these five.

The mode is held in a register. A new value is accepted only while an idle qualifier is high, so pin directions never change in the middle of a frame. A synchronous reset forces the isolated normal mode. Two enable outputs tell the controller section and the encoder/decoder section whether to run.

Top module: `endec_pin_mux`

## Requirements
- R1: While reset is held and on the first cycle after it, the active mode reads 00 (normal) and no pad output enable is set.
- R2: In mode 00 all eight output enables and pad data outputs are 0. The encoder inputs equal the controller's forward signals, and the controller's return signals equal the encoder/decoder outputs.
- R3: In mode 01 all eight output enables are 1. The pad data bits are, from bit 7 down to bit 0, the five encoder/decoder outputs followed by the three controller forward signals. The internal routing is the same as in mode 00.
- R4: In mode 10 the output enables are 8'h07 and pads 2:0 carry the controller forward signals. The controller return signals come from pads 7:3, and the encoder inputs are held at 0.
- R5: In mode 11 the output enables are 8'hF8 and pads 7:3 carry the encoder/decoder outputs. The encoder inputs come from pads 2:0, and the controller return signals, carrier and collision included, are held at 0.
- R6: The mode field (00 normal, 01 monitor, 10 bypass, 11 test) is loaded on a clock edge where the idle qualifier is 1, and shows on the active mode output from the next cycle. On any edge where the qualifier is 0, the active mode keeps its value.
- R7: controller_enable is 0 only in mode 11, and endec_enable is 0 only in mode 10.
- R8: A pad whose output enable is 0 has data output 0. Pad inputs have no effect on any internal signal outside the modes that make that pad an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_field | input | 2 | Requested mode from the control register |
| mode_load_ok | input | 1 | Idle qualifier; the mode is loaded while this is high |
| mac_fwd_i | input | 3 | Controller signals: transmit data, transmit enable, loopback control |
| mac_rev_o | output | 5 | To controller: transmit clock, receive data, receive clock, carrier, collision |
| codec_fwd_o | output | 3 | Encoder inputs: transmit data, transmit enable, loopback control |
| codec_rev_i | input | 5 | Encoder/decoder outputs, in the same order as mac_rev_o |
| pad_in | input | 8 | Pad input values |
| pad_out | output | 8 | Pad data outputs |
| pad_oe | output | 8 | Pad output enables |
| controller_enable | output | 1 | Controller section runs |
| endec_enable | output | 1 | Internal encoder/decoder runs |
| active_mode | output | 2 | Mode currently in force |

## Verification
The hardest situation to reach is a mode change requested while the qualifier is low, followed by a later qualified edge. Only that sequence shows that the request is held off and then taken on exactly the right cycle. The stimulus makes the qualifier rare in its random phase and holds a different mode on the field for several unqualified cycles before releasing it. The pad inputs are toggled while the pads are not inputs, which checks that the internal receive signals stay untouched in every mode.

// File: rtl/endec_pin_pkg.sv
// Package endec_pin_pkg
// Shared mode encoding, pin group sizes and the decoded routing controls
// for the encoder/decoder pin multiplexer. Assumes pins 0..N_FWD-1 carry
// controller-sourced signals and the rest carry encoder/decoder outputs.
package endec_pin_pkg;

    localparam int N_FWD  = 3;
    localparam int N_REV  = 5;
    localparam int N_PINS = N_FWD + N_REV;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_MONITOR = 2'b01,
        MODE_BYPASS  = 2'b10,
        MODE_TEST    = 2'b11
    } mode_t;

    typedef struct packed {
        logic [N_PINS-1:0] oe;       // pad output enables
        logic              fwd_pad;  // encoder inputs taken from pads
        logic              rev_pad;  // controller return taken from pads
        logic              mac_on;   // controller section runs
        logic              codec_on; // encoder/decoder section runs
    } route_t;

endpackage

// File: rtl/endec_mode_reg.sv
// Module endec_mode_reg
// Holds the mode in force. A synchronous active-low reset forces normal
// mode. A new field value is accepted only on edges where the idle
// qualifier is high. Assumes the qualifier is already synchronous to clk.
module endec_mode_reg
    import endec_pin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_field,
    input  logic       load_ok,
    output mode_t      mode_q
);

    // Mode register: reset to normal, load only while qualified.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_NORMAL;
        end else if (load_ok) begin
            mode_q <= mode_t'(mode_field);
        end
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_ok |=> $stable(mode_q)); // R6

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_ok |=> (mode_q == $past(mode_field))); // R6

endmodule

// File: rtl/endec_route_decode.sv
// Module endec_route_decode
// Turns the mode in force into the pad direction pattern, the source
// selects and the section enables. Purely combinational. Assumes the
// pin numbering of endec_pin_pkg.
module endec_route_decode
    import endec_pin_pkg::*;
(
    input  mode_t  mode,
    output route_t ctl
);

    localparam logic [N_PINS-1:0] OE_NONE = '0;
    localparam logic [N_PINS-1:0] OE_ALL  = '1;
    localparam logic [N_PINS-1:0] OE_FWD  = {{N_REV{1'b0}}, {N_FWD{1'b1}}};
    localparam logic [N_PINS-1:0] OE_REV  = ~OE_FWD;

    // Mode decode: one row per mode.
    always_comb begin
        ctl = '0;
        unique case (mode)
            MODE_NORMAL: begin
                ctl.oe       = OE_NONE;
                ctl.mac_on   = 1'b1;
                ctl.codec_on = 1'b1;
            end
            MODE_MONITOR: begin
                ctl.oe       = OE_ALL;
                ctl.mac_on   = 1'b1;
                ctl.codec_on = 1'b1;
            end
            MODE_BYPASS: begin
                ctl.oe       = OE_FWD;
                ctl.rev_pad  = 1'b1;
                ctl.mac_on   = 1'b1;
                ctl.codec_on = 1'b0;
            end
            MODE_TEST: begin
                ctl.oe       = OE_REV;
                ctl.fwd_pad  = 1'b1;
                ctl.mac_on   = 1'b0;
                ctl.codec_on = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/endec_pad_mux.sv
// Module endec_pad_mux
// Per-pin data steering between controller, encoder/decoder and pads.
// A pad with its enable off outputs 0. A disabled section's inputs are
// held at 0. Assumes the decoded controls are consistent: a pad
// selected as a source never has its enable on.
module endec_pad_mux
    import endec_pin_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  route_t             ctl,
    input  logic [N_FWD-1:0]   mac_fwd,
    input  logic [N_REV-1:0]   codec_rev,
    input  logic [N_PINS-1:0]  pad_in,
    output logic [N_PINS-1:0]  pad_out,
    output logic [N_FWD-1:0]   codec_fwd,
    output logic [N_REV-1:0]   mac_rev
);

    genvar i;

    // Forward pins: the controller drives the pad, the encoder reads the
    // controller or the pad.
    generate
        for (i = 0; i < N_FWD; i++) begin : g_fwd
            always_comb begin
                pad_out[i]   = ctl.oe[i] & mac_fwd[i];
                codec_fwd[i] = ctl.codec_on &
                               (ctl.fwd_pad ? pad_in[i] : mac_fwd[i]);
            end
        end
    endgenerate

    // Return pins: the encoder/decoder drives the pad, the controller reads
    // the encoder/decoder or the pad.
    generate
        for (i = 0; i < N_REV; i++) begin : g_rev
            always_comb begin
                pad_out[N_FWD+i] = ctl.oe[N_FWD+i] & codec_rev[i];
                mac_rev[i]       = ctl.mac_on &
                                   (ctl.rev_pad ? pad_in[N_FWD+i] : codec_rev[i]);
            end
        end
    endgenerate

    AST_OFF_PAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~ctl.oe) == '0); // R8

    AST_MAC_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.mac_on |-> (mac_rev == '0)); // R5

    AST_CODEC_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.codec_on |-> (codec_fwd == '0)); // R4

endmodule

// File: rtl/endec_pin_mux.sv
// Module endec_pin_mux
// Top of the encoder/decoder pin multiplexer: mode register, mode decode
// and per-pin steering. Assumes all inputs are synchronous to clk; the
// pad signals model a tri-state pad as separate data, enable and input.
module endec_pin_mux
    import endec_pin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_field,
    input  logic              mode_load_ok,
    input  logic [N_FWD-1:0]  mac_fwd_i,
    output logic [N_REV-1:0]  mac_rev_o,
    output logic [N_FWD-1:0]  codec_fwd_o,
    input  logic [N_REV-1:0]  codec_rev_i,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic              controller_enable,
    output logic              endec_enable,
    output logic [1:0]        active_mode
);

    mode_t  mode_q;
    route_t ctl;

    endec_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_field (mode_field),
        .load_ok    (mode_load_ok),
        .mode_q     (mode_q)
    );

    endec_route_decode u_dec (
        .mode (mode_q),
        .ctl  (ctl)
    );

    endec_pad_mux u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mac_fwd   (mac_fwd_i),
        .codec_rev (codec_rev_i),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .codec_fwd (codec_fwd_o),
        .mac_rev   (mac_rev_o)
    );

    // Drive the top-level control outputs from the decoded mode.
    always_comb begin
        pad_oe            = ctl.oe;
        controller_enable = ctl.mac_on;
        endec_enable      = ctl.codec_on;
        active_mode       = mode_q;
    end

    AST_RESET_ISOLATED: assert property (@(posedge clk)
        !rst_n |=> (active_mode == 2'b00 && pad_oe == '0)); // R1

    AST_NORMAL_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        (active_mode == 2'b00) |-> (pad_oe == '0 && pad_out == '0)); // R2

    AST_MONITOR_ALL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (active_mode == 2'b01) |-> (pad_oe == '1)); // R3

    AST_BYPASS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (active_mode == 2'b10) |-> (pad_oe == 8'h07)); // R4

    AST_TEST_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (active_mode == 2'b11) |-> (pad_oe == 8'hF8)); // R5

    AST_ONE_SECTION_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (controller_enable | endec_enable)); // R7

endmodule

// File: tb/endec_pin_mux_test.sv
module endec_pin_mux_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_field;
    logic       mode_load_ok;
    logic [2:0] mac_fwd_i;
    logic [4:0] mac_rev_o;
    logic [2:0] codec_fwd_o;
    logic [4:0] codec_rev_i;
    logic [7:0] pad_in;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic       controller_enable;
    logic       endec_enable;
    logic [1:0] active_mode;

    int total = 0;
    int bad   = 0;
    logic [1:0] model_mode;

    endec_pin_mux uut (
        .clk(clk), .rst_n(rst_n), .mode_field(mode_field),
        .mode_load_ok(mode_load_ok), .mac_fwd_i(mac_fwd_i),
        .mac_rev_o(mac_rev_o), .codec_fwd_o(codec_fwd_o),
        .codec_rev_i(codec_rev_i), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .controller_enable(controller_enable),
        .endec_enable(endec_enable), .active_mode(active_mode)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] exp_oe(input logic [1:0] m);
        case (m)
            2'b00:   return 8'h00;
            2'b01:   return 8'hFF;
            2'b10:   return 8'h07;
            default: return 8'hF8;
        endcase
    endfunction

    function automatic logic [7:0] exp_pad(input logic [1:0] m);
        return exp_oe(m) & {codec_rev_i, mac_fwd_i};
    endfunction

    function automatic logic [2:0] exp_cfwd(input logic [1:0] m);
        case (m)
            2'b10:   return 3'b000;
            2'b11:   return pad_in[2:0];
            default: return mac_fwd_i;
        endcase
    endfunction

    function automatic logic [4:0] exp_mrev(input logic [1:0] m);
        case (m)
            2'b10:   return pad_in[7:3];
            2'b11:   return 5'b00000;
            default: return codec_rev_i;
        endcase
    endfunction

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check("R6", "active_mode", {6'd0, active_mode}, {6'd0, model_mode});
        check(req, "pad_oe", pad_oe, exp_oe(model_mode));
        check(req, "pad_out", pad_out, exp_pad(model_mode));
        check(req, "codec_fwd", {5'd0, codec_fwd_o}, {5'd0, exp_cfwd(model_mode)});
        check(req, "mac_rev", {3'd0, mac_rev_o}, {3'd0, exp_mrev(model_mode)});
        check("R7", "enables", {6'd0, controller_enable, endec_enable},
              {6'd0, model_mode != 2'b11, model_mode != 2'b10});
    endtask

    task automatic randomize_data();
        mac_fwd_i   = 3'($urandom);
        codec_rev_i = 5'($urandom);
        pad_in      = 8'($urandom);
    endtask

    // One cycle: drive at negedge, check, then update the model at posedge.
    task automatic step(input logic [1:0] f, input logic ld);
        @(negedge clk);
        mode_field   = f;
        mode_load_ok = ld;
        randomize_data();
        #2;
        check_all(mode_req(model_mode));
        @(posedge clk);
        if (!rst_n) model_mode = 2'b00;
        else if (ld) model_mode = f;
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; mode_field = 2'b11; mode_load_ok = 1'b1;
        mac_fwd_i = '0; codec_rev_i = '0; pad_in = '0;
        model_mode = 2'b00;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset forces normal and isolated pads despite a test request
        check("R1", "reset mode", {6'd0, active_mode}, 8'd0);
        check("R1", "reset oe", pad_oe, 8'h00);
        rst_n = 1'b1;
        mode_load_ok = 1'b0;
        @(posedge clk);
        #1;
        // R1: first cycle after reset still normal
        check("R1", "post-reset mode", {6'd0, active_mode}, 8'd0);

        // R6: unqualified requests are ignored for several cycles
        for (int k = 0; k < 6; k++) step(2'b11, 1'b0);
        // Directed visit of every mode with one qualified load each
        for (int m = 0; m < 4; m++) begin
            step(2'(m), 1'b1);
            for (int k = 0; k < 4; k++) step(2'(3 - m), 1'b0);
        end

        // R8: in normal mode, toggling pad inputs leaves internal signals
        step(2'b00, 1'b1);
        @(negedge clk);
        mode_load_ok = 1'b0;
        codec_rev_i = 5'b10101; mac_fwd_i = 3'b011;
        pad_in = 8'h00; #2;
        check("R8", "normal mac_rev pads low", {3'd0, mac_rev_o}, 8'h15);
        pad_in = 8'hFF; #2;
        check("R8", "normal mac_rev pads high", {3'd0, mac_rev_o}, 8'h15);
        check("R8", "normal codec_fwd pads high", {5'd0, codec_fwd_o}, 8'h03);
        check("R8", "normal pad_out", pad_out, 8'h00);

        // R8: bypass mode, pads 2:0 are outputs so their inputs are ignored
        step(2'b10, 1'b1);
        @(negedge clk);
        mode_load_ok = 1'b0;
        pad_in = 8'h07; #2;
        check("R8", "bypass codec_fwd", {5'd0, codec_fwd_o}, 8'h00);
        check("R8", "bypass mac_rev", {3'd0, mac_rev_o}, 8'h00);

        // Random phase with rare qualified loads
        for (int k = 0; k < 400; k++)
            step(2'($urandom), ($urandom % 4) == 0);

        // R6 again: reset in mid-run returns to normal
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        model_mode = 2'b00;
        #1;
        check("R1", "mid-run reset", {6'd0, active_mode}, 8'd0);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) step(2'($urandom), 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule